// File: doc/BRIEF.md
# Auto-Incrementing SRAM Access Window

This block gives a host a small register window into a device-internal SRAM. The host sees four 32-bit registers: a read pointer, a write pointer, a write-data port and a read-data port. After it loads a pointer, the host can stream through memory with repeated accesses to the matching data port. Each data access moves its pointer on by one dword, so the host never has to write the address again. The block drives a single-port synchronous SRAM, which returns read data one cycle after the request.

The read and write sides keep separate pointers. A read stream and a write stream can therefore be interleaved without either one disturbing the other. Read data is fetched ahead of time. Loading the read pointer starts a fetch at once. Every read of the read-data port returns the fetched word and starts the fetch of the next one, so back-to-back host reads run at one per cycle.

A build parameter selects a peripheral variant. In that variant, pointer bits 15:0 are a register offset and bits 25:24 hold the access size minus one. Writes then touch only the low-order bytes that the size calls for. Read data is masked to the same width, and the pointer steps only inside the offset field.

Top module: `sram_window`

## Requirements
- R1: After reset, both pointers read back as zero, hst_rvalid is low and the SRAM is not enabled.
- R2: The registers sit at byte offsets WIN_BASE+0x00C (read pointer), +0x010 (write pointer), +0x018 (write data) and +0x01C (read data), with WIN_BASE = 0x400 by default. A read of any other offset, or of the write-data port, returns zero. A write to any other offset, or to the read-data port, changes no pointer and makes no SRAM access.
- R3: A write to the read pointer stores the full 32-bit value, and the pointer reads back that value. In the same cycle, the write issues an SRAM read at word index value[MEM_AW+1:2].
- R4: A read of the read-data port returns the dword held for the current read pointer. hst_rvalid and hst_rdata present the result in the cycle after the read. The same read advances the pointer and fetches the next dword in the same cycle, so consecutive reads return consecutive dwords even when they are issued on back-to-back cycles.
- R5: A write to the write-data port writes hst_wdata to the SRAM in the same cycle, at word index wr_ptr[MEM_AW+1:2], and advances the write pointer. In the default mode all four byte enables are set and the pointer advances by 4.
- R6: The read and write pointers are independent. Write-side accesses never move the read pointer, and read-side accesses never move the write pointer.
- R7: In the default mode the pointers wrap modulo 2^32, so 0xFFFFFFFC advances to 0x00000000.
- R8: In the peripheral variant, bits 15:0 are the offset and bits 25:24 give the size as bytes minus one. A write enables bytes 0 through size (mem_be 0001, 0011, 0111 or 1111). Advancing adds 4 to bits 15:0, wraps within 16 bits and leaves bits 31:16 unchanged.
- R9: In the peripheral variant, data read from the read-data port is masked to its low size+1 bytes, using the size field of the read pointer at the time of the read.
- R10: The SRAM is enabled only in a cycle that writes the read pointer, reads the read-data port or writes the write-data port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_valid | input | 1 | Host register access this cycle |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_addr | input | HA_W | Register byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Read result, valid with hst_rvalid |
| hst_rvalid | output | 1 | Pulses the cycle after each host read |
| mem_en | output | 1 | SRAM enable |
| mem_we | output | 1 | SRAM write strobe |
| mem_be | output | 4 | SRAM byte enables |
| mem_addr | output | MEM_AW | SRAM word index |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, one cycle after the request |

## Verification
The bench issues back-to-back read-data reads right after loading the pointer. A design that returned the stale buffer in the cycle the fetch lands, instead of forwarding the SRAM output, would repeat the previous word or return zero. The bench interleaves write-data and read-data accesses, which exposes any shared or cross-coupled pointer as a skipped or duplicated dword. It drives both pointers across the top of the address space, where a narrow adder would stall or corrupt the high bits. In the peripheral variant it uses every size and the 16-bit offset wrap, which catch wrong byte enables, unmasked read data and a carry leaking into the size field.

// File: rtl/sram_window_pkg.sv
package sram_window_pkg;

  localparam int unsigned OFF_RPTR = 32'h00C;
  localparam int unsigned OFF_WPTR = 32'h010;
  localparam int unsigned OFF_WDAT = 32'h018;
  localparam int unsigned OFF_RDAT = 32'h01C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RPTR,
    SEL_WPTR,
    SEL_WDAT,
    SEL_RDAT
  } win_sel_e;

  // Advance a pointer by one dword; peripheral form keeps bits 31:16.
  function automatic logic [31:0] ptr_step(input logic [31:0] p, input bit periph);
    if (periph) return {p[31:16], p[15:0] + 16'd4};
    return p + 32'd4;
  endfunction

  // Byte enables implied by a pointer's size field.
  function automatic logic [3:0] size_be(input logic [31:0] p, input bit periph);
    if (!periph) return 4'hF;
    case (p[25:24])
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      2'd2:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

endpackage

// File: rtl/swin_decode.sv
module swin_decode
  import sram_window_pkg::*;
#(
  parameter int HA_W     = 12,
  parameter int WIN_BASE = 32'h400
) (
  input  logic [HA_W-1:0] hst_addr,
  output win_sel_e        sel
);
  localparam logic [HA_W-1:0] A_RPTR = HA_W'(WIN_BASE + OFF_RPTR);
  localparam logic [HA_W-1:0] A_WPTR = HA_W'(WIN_BASE + OFF_WPTR);
  localparam logic [HA_W-1:0] A_WDAT = HA_W'(WIN_BASE + OFF_WDAT);
  localparam logic [HA_W-1:0] A_RDAT = HA_W'(WIN_BASE + OFF_RDAT);

  always_comb begin
    case (hst_addr)
      A_RPTR:  sel = SEL_RPTR;
      A_WPTR:  sel = SEL_WPTR;
      A_WDAT:  sel = SEL_WDAT;
      A_RDAT:  sel = SEL_RDAT;
      default: sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/swin_rd_port.sv
module swin_rd_port
  import sram_window_pkg::*;
#(
  parameter bit PERIPH = 1'b0,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [31:0]       load_val,
  input  logic              step,
  input  logic [31:0]       mem_rdata,
  output logic [31:0]       rd_ptr,
  output logic              fetch_en,
  output logic [MEM_AW-1:0] fetch_idx,
  output logic [31:0]       buf_eff
);
  logic [31:0] ptr_q;
  logic [31:0] buf_q;
  logic        pend_q;
  logic [31:0] fetch_ptr;

  assign fetch_en  = load | step;
  assign fetch_ptr = load ? load_val : ptr_step(ptr_q, PERIPH);
  assign fetch_idx = fetch_ptr[MEM_AW+1:2];
  // A fetch issued last cycle lands now: forward it past the buffer.
  assign buf_eff   = pend_q ? mem_rdata : buf_q;
  assign rd_ptr    = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      buf_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (fetch_en) ptr_q <= fetch_ptr;
      if (pend_q)   buf_q <= mem_rdata;
      pend_q <= fetch_en;
    end
  end
endmodule

// File: rtl/swin_wr_port.sv
module swin_wr_port
  import sram_window_pkg::*;
#(
  parameter bit PERIPH = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] load_val,
  input  logic        step,
  output logic [31:0] wr_ptr
);
  logic [31:0] ptr_q;

  assign wr_ptr = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr_q <= '0;
    else if (load) ptr_q <= load_val;
    else if (step) ptr_q <= ptr_step(ptr_q, PERIPH);
  end
endmodule

// File: rtl/sram_window.sv
module sram_window
  import sram_window_pkg::*;
#(
  parameter bit PERIPH   = 1'b0,
  parameter int MEM_AW   = 10,
  parameter int HA_W     = 12,
  parameter int WIN_BASE = 32'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_valid,
  input  logic              hst_write,
  input  logic [HA_W-1:0]   hst_addr,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  output logic              hst_rvalid,
  output logic              mem_en,
  output logic              mem_we,
  output logic [3:0]        mem_be,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  win_sel_e          sel;
  logic              ev_rptr_wr;
  logic              ev_wptr_wr;
  logic              ev_wdat_wr;
  logic              ev_rdat_rd;
  logic              ev_any_rd;
  logic [31:0]       rd_ptr;
  logic [31:0]       wr_ptr;
  logic              fetch_en;
  logic [MEM_AW-1:0] fetch_idx;
  logic [31:0]       buf_eff;
  logic [31:0]       rd_next;

  swin_decode #(.HA_W(HA_W), .WIN_BASE(WIN_BASE)) u_dec (
    .hst_addr (hst_addr),
    .sel      (sel)
  );

  // Named host events.
  assign ev_rptr_wr = hst_valid &  hst_write & (sel == SEL_RPTR);
  assign ev_wptr_wr = hst_valid &  hst_write & (sel == SEL_WPTR);
  assign ev_wdat_wr = hst_valid &  hst_write & (sel == SEL_WDAT);
  assign ev_rdat_rd = hst_valid & ~hst_write & (sel == SEL_RDAT);
  assign ev_any_rd  = hst_valid & ~hst_write;

  swin_rd_port #(.PERIPH(PERIPH), .MEM_AW(MEM_AW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_rptr_wr),
    .load_val  (hst_wdata),
    .step      (ev_rdat_rd),
    .mem_rdata (mem_rdata),
    .rd_ptr    (rd_ptr),
    .fetch_en  (fetch_en),
    .fetch_idx (fetch_idx),
    .buf_eff   (buf_eff)
  );

  swin_wr_port #(.PERIPH(PERIPH)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_wptr_wr),
    .load_val (hst_wdata),
    .step     (ev_wdat_wr),
    .wr_ptr   (wr_ptr)
  );

  // One host access per cycle, so a write and a fetch never collide.
  assign mem_en    = fetch_en | ev_wdat_wr;
  assign mem_we    = ev_wdat_wr;
  assign mem_addr  = ev_wdat_wr ? wr_ptr[MEM_AW+1:2] : fetch_idx;
  assign mem_be    = ev_wdat_wr ? size_be(wr_ptr, PERIPH) : 4'h0;
  assign mem_wdata = hst_wdata;

  always_comb begin
    case (sel)
      SEL_RPTR: rd_next = rd_ptr;
      SEL_WPTR: rd_next = wr_ptr;
      SEL_RDAT: rd_next = buf_eff & be_mask(size_be(rd_ptr, PERIPH));
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hst_rdata  <= '0;
      hst_rvalid <= 1'b0;
    end else begin
      hst_rvalid <= ev_any_rd;
      if (ev_any_rd) hst_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/sram_window_chk.sv
module sram_window_chk
  import sram_window_pkg::*;
#(
  parameter bit PERIPH   = 1'b0,
  parameter int MEM_AW   = 10,
  parameter int HA_W     = 12,
  parameter int WIN_BASE = 32'h400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hst_valid,
  input logic              hst_write,
  input logic [HA_W-1:0]   hst_addr,
  input logic [31:0]       hst_wdata,
  input logic              hst_rvalid,
  input logic              mem_en,
  input logic              mem_we,
  input logic [3:0]        mem_be,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [31:0]       rd_ptr,
  input logic [31:0]       wr_ptr
);
  localparam logic [HA_W-1:0] C_RPTR = HA_W'(WIN_BASE + OFF_RPTR);
  localparam logic [HA_W-1:0] C_WDAT = HA_W'(WIN_BASE + OFF_WDAT);

  logic c_rptr_wr;
  logic c_wdat_wr;
  assign c_rptr_wr = hst_valid && hst_write && (hst_addr == C_RPTR);
  assign c_wdat_wr = hst_valid && hst_write && (hst_addr == C_WDAT);

  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !hst_valid |-> !mem_en); // R10
  AST_RPTR_FETCH_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    c_rptr_wr |-> (mem_en && !mem_we && mem_addr == hst_wdata[MEM_AW+1:2])); // R3
  AST_RPTR_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    c_rptr_wr |=> (rd_ptr == $past(hst_wdata))); // R3
  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    c_wdat_wr |=> (wr_ptr == ptr_step($past(wr_ptr), PERIPH))); // R5
  AST_RPTR_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    c_wdat_wr |=> $stable(rd_ptr)); // R6
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    hst_rvalid |-> $past(hst_valid && !hst_write)); // R4
  AST_BE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_be == 4'b0001 || mem_be == 4'b0011 ||
                mem_be == 4'b0111 || mem_be == 4'b1111)); // R8
endmodule

bind sram_window sram_window_chk #(
  .PERIPH(PERIPH), .MEM_AW(MEM_AW), .HA_W(HA_W), .WIN_BASE(WIN_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hst_valid  (hst_valid),
  .hst_write  (hst_write),
  .hst_addr   (hst_addr),
  .hst_wdata  (hst_wdata),
  .hst_rvalid (hst_rvalid),
  .mem_en     (mem_en),
  .mem_we     (mem_we),
  .mem_be     (mem_be),
  .mem_addr   (mem_addr),
  .rd_ptr     (rd_ptr),
  .wr_ptr     (wr_ptr)
);

// File: tb/test_sram_window.sv
module test_sram_window;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hst_valid = 1'b0;
  logic hst_write = 1'b0;
  logic [11:0] hst_addr = '0;
  logic [31:0] hst_wdata = '0;

  logic [31:0]   d_rdata [2];
  logic          d_rv    [2];
  logic          d_en    [2];
  logic          d_we    [2];
  logic [3:0]    d_be    [2];
  logic [AW-1:0] d_addr  [2];
  logic [31:0]   d_wdata [2];
  logic [31:0]   d_mrd   [2];

  logic [31:0] sm [2][DEPTH];
  logic [31:0] rm [2][DEPTH];
  logic [31:0] rp [2];
  logic [31:0] wp [2];
  logic [31:0] bufv [2];
  logic [31:0] exp_rd [2];
  logic exp_rv = 1'b0;
  string tag = "R1";
  string exp_tag = "R1";
  logic run = 1'b0;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_window #(.PERIPH(1'b0), .MEM_AW(AW)) i_sram_window (
    .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_write(hst_write),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(d_rdata[0]),
    .hst_rvalid(d_rv[0]), .mem_en(d_en[0]), .mem_we(d_we[0]), .mem_be(d_be[0]),
    .mem_addr(d_addr[0]), .mem_wdata(d_wdata[0]), .mem_rdata(d_mrd[0]));

  sram_window #(.PERIPH(1'b1), .MEM_AW(AW)) i_sram_window_prph (
    .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_write(hst_write),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(d_rdata[1]),
    .hst_rvalid(d_rv[1]), .mem_en(d_en[1]), .mem_we(d_we[1]), .mem_be(d_be[1]),
    .mem_addr(d_addr[1]), .mem_wdata(d_wdata[1]), .mem_rdata(d_mrd[1]));

  // Behavioural SRAMs: byte-enabled write, registered read, output held.
  for (genvar g = 0; g < 2; g++) begin : g_mem
    always @(posedge clk) begin
      if (d_en[g] && d_we[g]) begin
        for (int b = 0; b < 4; b++)
          if (d_be[g][b]) sm[g][d_addr[g]][8*b +: 8] <= d_wdata[g][8*b +: 8];
      end else if (d_en[g]) begin
        d_mrd[g] <= sm[g][d_addr[g]];
      end
    end
  end

  function automatic logic [31:0] m_step(int k, logic [31:0] p);
    if (k == 1) return {p[31:16], 16'(p[15:0] + 16'd4)};
    return p + 32'd4;
  endfunction

  function automatic int m_bytes(int k, logic [31:0] p);
    if (k == 0) return 4;
    return int'(p[25:24]) + 1;
  endfunction

  function automatic logic [31:0] m_mask(int n);
    logic [31:0] m = '0;
    for (int b = 0; b < n; b++) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic int m_idx(logic [31:0] p);
    return int'(p[AW+1:2]);
  endfunction

  task automatic chk(input bit ok, input string t, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  // Reference model and per-cycle comparison, mid-cycle.
  always @(negedge clk) begin
    if (run) begin
      bit e_en, e_we;
      int e_idx;
      logic [3:0] e_be;
      for (int k = 0; k < 2; k++) begin
        chk(d_rv[k] === exp_rv, exp_tag, $sformatf("rvalid[%0d]", k),
            32'(d_rv[k]), 32'(exp_rv));
        if (exp_rv)
          chk(d_rdata[k] === exp_rd[k], exp_tag, $sformatf("rdata[%0d]", k),
              d_rdata[k], exp_rd[k]);
      end
      for (int k = 0; k < 2; k++) begin
        e_en = 1'b0; e_we = 1'b0; e_idx = 0; e_be = 4'h0;
        if (hst_valid && hst_write) begin
          case (hst_addr)
            12'h40C: begin
              e_en = 1'b1; e_idx = m_idx(hst_wdata);
              rp[k] = hst_wdata; bufv[k] = rm[k][e_idx];
            end
            12'h410: wp[k] = hst_wdata;
            12'h418: begin
              e_en = 1'b1; e_we = 1'b1; e_idx = m_idx(wp[k]);
              e_be = 4'((1 << m_bytes(k, wp[k])) - 1);
              for (int b = 0; b < m_bytes(k, wp[k]); b++)
                rm[k][e_idx][8*b +: 8] = hst_wdata[8*b +: 8];
              wp[k] = m_step(k, wp[k]);
            end
            default: ;
          endcase
        end else if (hst_valid) begin
          case (hst_addr)
            12'h40C: exp_rd[k] = rp[k];
            12'h410: exp_rd[k] = wp[k];
            12'h41C: begin
              exp_rd[k] = bufv[k] & m_mask(m_bytes(k, rp[k]));
              rp[k] = m_step(k, rp[k]);
              e_en = 1'b1; e_idx = m_idx(rp[k]);
              bufv[k] = rm[k][e_idx];
            end
            default: exp_rd[k] = '0;
          endcase
        end
        chk(d_en[k] === e_en, tag, $sformatf("mem_en[%0d]", k), 32'(d_en[k]), 32'(e_en));
        if (e_en) begin
          chk(d_we[k] === e_we, tag, $sformatf("mem_we[%0d]", k), 32'(d_we[k]), 32'(e_we));
          chk(d_addr[k] === AW'(e_idx), tag, $sformatf("mem_addr[%0d]", k),
              32'(d_addr[k]), 32'(e_idx));
        end
        if (e_we) begin
          chk(d_be[k] === e_be, tag, $sformatf("mem_be[%0d]", k), 32'(d_be[k]), 32'(e_be));
          chk(d_wdata[k] === hst_wdata, tag, $sformatf("mem_wdata[%0d]", k),
              d_wdata[k], hst_wdata);
        end
      end
      exp_rv = hst_valid && !hst_write;
      exp_tag = tag;
    end
  end

  task automatic acc(input bit w, input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    hst_valid = 1'b1; hst_write = w; hst_addr = a; hst_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      hst_valid = 1'b0; hst_write = 1'b0; hst_addr = '0; hst_wdata = '0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < DEPTH; i++) begin
        sm[k][i] = (32'(i) * 32'h0100_0193) ^ 32'hA5A5_0000;
        rm[k][i] = sm[k][i];
      end
      rp[k] = '0; wp[k] = '0; bufv[k] = '0; exp_rd[k] = '0;
      d_mrd[k] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state seen at the ports
    for (int k = 0; k < 2; k++) begin
      chk(d_rv[k] === 1'b0, "R1", "rvalid after reset", 32'(d_rv[k]), 0);
      chk(d_en[k] === 1'b0, "R1", "mem_en after reset", 32'(d_en[k]), 0);
    end
    run = 1'b1;
    tag = "R1";
    acc(0, 12'h40C, 0); acc(0, 12'h410, 0); idle(2);

    tag = "R3";
    acc(1, 12'h40C, 32'h0000_0040); acc(0, 12'h40C, 0); idle(1);
    tag = "R4";
    acc(1, 12'h40C, 32'h0000_0080);
    acc(0, 12'h41C, 0); acc(0, 12'h41C, 0); acc(0, 12'h41C, 0); acc(0, 12'h41C, 0);
    idle(1); acc(0, 12'h41C, 0); acc(0, 12'h40C, 0); idle(2);

    tag = "R5";
    acc(1, 12'h410, 32'h0000_0100);
    acc(1, 12'h418, 32'hDEAD_0001); acc(1, 12'h418, 32'hDEAD_0002);
    acc(1, 12'h418, 32'hDEAD_0003); acc(0, 12'h410, 0);
    acc(1, 12'h40C, 32'h0000_0100);
    acc(0, 12'h41C, 0); acc(0, 12'h41C, 0); acc(0, 12'h41C, 0); idle(2);

    tag = "R6";
    acc(1, 12'h40C, 32'h0000_0200); acc(1, 12'h410, 32'h0000_0300);
    for (int i = 0; i < 4; i++) begin
      acc(1, 12'h418, 32'hC0DE_0000 + 32'(i));
      acc(0, 12'h41C, 0);
    end
    acc(0, 12'h40C, 0); acc(0, 12'h410, 0);
    acc(1, 12'h40C, 32'h0000_0300);
    for (int i = 0; i < 4; i++) acc(0, 12'h41C, 0);
    idle(2);

    tag = "R7";
    acc(1, 12'h410, 32'hFFFF_FFF8);
    acc(1, 12'h418, 32'h7777_0001); acc(1, 12'h418, 32'h7777_0002);
    acc(1, 12'h418, 32'h7777_0003); acc(0, 12'h410, 0);
    acc(1, 12'h40C, 32'hFFFF_FFFC);
    acc(0, 12'h41C, 0); acc(0, 12'h41C, 0); acc(0, 12'h40C, 0); idle(2);

    tag = "R8";
    acc(1, 12'h410, 32'h0100_0040); acc(1, 12'h418, 32'h1122_3344);
    acc(1, 12'h410, 32'h0000_0044); acc(1, 12'h418, 32'h5566_7788);
    acc(1, 12'h410, 32'h0200_0048); acc(1, 12'h418, 32'h99AA_BBCC);
    acc(1, 12'h410, 32'h0300_004C); acc(1, 12'h418, 32'hDDEE_FF00);
    acc(1, 12'h40C, 32'h0300_0040);
    for (int i = 0; i < 4; i++) acc(0, 12'h41C, 0);
    acc(1, 12'h410, 32'h0300_FFFC);
    acc(1, 12'h418, 32'h1357_9BDF); acc(1, 12'h418, 32'h2468_ACE0);
    acc(0, 12'h410, 0); idle(2);

    tag = "R9";
    acc(1, 12'h40C, 32'h0000_0040); acc(0, 12'h41C, 0);
    acc(1, 12'h40C, 32'h0100_0080); acc(0, 12'h41C, 0);
    acc(1, 12'h40C, 32'h0200_0084); acc(0, 12'h41C, 0);
    acc(0, 12'h40C, 0); idle(2);

    tag = "R2";
    acc(1, 12'h410, 32'h0000_0010);
    acc(1, 12'h414, 32'h0000_0999); acc(1, 12'h41C, 32'h0000_0888);
    acc(1, 12'h400, 32'h1234_5678);
    acc(0, 12'h410, 0); acc(0, 12'h40C, 0);
    acc(0, 12'h414, 0); acc(0, 12'h418, 0); acc(0, 12'h000, 0);
    idle(2);

    tag = "R10";
    idle(4);
    acc(0, 12'h40C, 0); acc(1, 12'h410, 32'h40); idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule